// File: doc/BRIEF.md
# Z80 Machine-Cycle Bus Sequencer

This block produces the external bus pattern of a Z80-style processor one half T-state at a time. Each clock of `clk` is one half T-state, so every T-state gives two bus samples. Each sample carries the address, the memory request strobe, the I/O request strobe and the refresh strobe. A controller feeds the block with machine-cycle commands through a valid/ready handshake. Each command has a kind, an address and, for internal cycles, a T-state count. The block then plays out the matching strobe pattern half-cycle by half-cycle.

The block holds the interrupt-page register I and the refresh counter R. The opcode fetch uses them for its refresh address, and internal cycles can use them too. Many cycles drive no bus transfer. Even then the address bus always carries a defined value, because contention logic outside the block decodes that address. After reset there is a fixed lead-in of three T-states before the first command is taken. With no command in progress the bus shows address 0xFFFF with all strobes low.

Top module: `z80_bus_seq`

## Requirements
- R1: After reset is released, the first 6 half-cycles (3 T-states) show `bus_addr`=0xFFFF, all strobes low and `cmd_ready` low. `cmd_ready` is high in the 7th half-cycle.
- R2: When no command is in progress, the bus shows 0xFFFF with `mreq`, `ioreq` and `rfsh` low, `busy` low and `cmd_ready` high.
- R3: An opcode fetch (kind 0) lasts 8 half-cycles, numbered h0..h7. Halves h0..h3 drive the command address, with `mreq` high in h1..h3. Halves h4..h7 drive {I,R} with `rfsh` high throughout and `mreq` high in h5..h6.
- R4: R advances by one at the end of each opcode fetch. The refresh address in that fetch shows R before the step. Only R[6:0] counts (0x7F becomes 0x00); R[7] is kept.
- R5: A memory read (kind 1) or memory write (kind 2) lasts 6 half-cycles. It drives the command address throughout, with `mreq` high in h1..h4.
- R6: An I/O read (kind 3) or I/O write (kind 4) lasts 8 half-cycles. It drives the command address throughout, with `ioreq` high in h2..h6 and `mreq` low.
- R7: An internal cycle on the refresh address (kind 5) lasts 2*N half-cycles, where N is `cmd_count`; a count of 0 is taken as 1. It drives the current {I,R} with all strobes low.
- R8: An internal cycle on a held address (kind 6, and kind 7 the same) lasts 2*N half-cycles, with the same count rule as R7. It drives the command address with all strobes low.
- R9: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and its h0 appears in the next half-cycle. `busy` is high in every half except the last. `cmd_ready` is high in the last half, so a command offered there follows with no gap.
- R10: A write on `ir_wr` loads I from `ir_din[15:8]` and R from `ir_din[7:0]`. It takes priority over the R step of a fetch ending on the same edge.
- R11: `mreq` and `ioreq` are never high together, and `rfsh` is never high together with `ioreq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half T-state clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block can take a command this edge |
| cmd_kind | input | 3 | Command kind (0 fetch, 1 read, 2 write, 3 I/O read, 4 I/O write, 5 internal on {I,R}, 6/7 internal on held address) |
| cmd_addr | input | 16 | Address for the command |
| cmd_count | input | CW | T-state count for internal cycles |
| ir_wr | input | 1 | Load I and R |
| ir_din | input | 16 | Value for {I,R} |
| busy | output | 1 | A command is running and is not in its last half |
| bus_addr | output | 16 | Address bus sample for this half-cycle |
| mreq | output | 1 | Memory request, active high |
| ioreq | output | 1 | I/O request, active high |
| rfsh | output | 1 | Refresh, active high |

## Verification
The sequencer runs on random mixes of every command kind, random addresses and random internal counts, with random idle gaps and random I/R loads. Every half-cycle is compared with a model of the expected pattern. Back-to-back commands show that no half-cycle is lost or repeated at the command boundary. Internal cycles after a fetch show that the refresh counter stepped exactly once. Directed cases cover further corners:
- R at 0x7F and 0xFF, which shows that only the low seven bits wrap.
- A count of zero.
- An I/R load on the final edge of a fetch, which separates load priority from the R step.
- The reset lead-in, which tells apart an off-by-one length.

// File: rtl/z80_bus_seq.sv
module z80_bus_seq #(
  parameter int CW       = 4,
  parameter int LEADIN_T = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_kind,
  input  logic [15:0]   cmd_addr,
  input  logic [CW-1:0] cmd_count,
  input  logic          ir_wr,
  input  logic [15:0]   ir_din,
  output logic          busy,
  output logic [15:0]   bus_addr,
  output logic          mreq,
  output logic          ioreq,
  output logic          rfsh
);
  localparam int HW     = (CW + 1 > 4) ? CW + 1 : 4;
  localparam int LEAD_H = 2 * LEADIN_T;
  localparam int LW     = $clog2(LEAD_H + 1);

  localparam logic [2:0] K_FETCH = 3'd0;
  localparam logic [2:0] K_RD    = 3'd1;
  localparam logic [2:0] K_WR    = 3'd2;
  localparam logic [2:0] K_IORD  = 3'd3;
  localparam logic [2:0] K_IOWR  = 3'd4;
  localparam logic [2:0] K_INTIR = 3'd5;

  logic [LW-1:0] lead;
  logic          active;
  logic [2:0]    kind;
  logic [15:0]   caddr;
  logic [CW-1:0] cnt;
  logic [HW-1:0] half;
  logic [HW-1:0] len;
  logic [7:0]    ireg, rreg;
  logic          lead_done, last, accept, is_fetch, is_mem, is_io;

  assign lead_done = (lead == LW'(LEAD_H));
  assign is_fetch  = (kind == K_FETCH);
  assign is_mem    = (kind == K_RD) || (kind == K_WR);
  assign is_io     = (kind == K_IORD) || (kind == K_IOWR);

  always_comb begin
    if (is_fetch || is_io) len = HW'(8);
    else if (is_mem)       len = HW'(6);
    else                   len = HW'({cnt, 1'b0});
  end

  assign last      = active && (half == len - HW'(1));
  assign busy      = active && !last;
  assign cmd_ready = lead_done && !busy;
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead   <= '0;
      active <= 1'b0;
      kind   <= K_FETCH;
      caddr  <= '0;
      cnt    <= '0;
      half   <= '0;
    end else begin
      if (!lead_done) lead <= lead + LW'(1);
      if (accept) begin
        active <= 1'b1;
        kind   <= cmd_kind;
        caddr  <= cmd_addr;
        cnt    <= (cmd_count == '0) ? CW'(1) : cmd_count;
        half   <= '0;
      end else if (last) begin
        active <= 1'b0;
      end else if (active) begin
        half <= half + HW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ireg <= '0;
      rreg <= '0;
    end else if (ir_wr) begin
      ireg <= ir_din[15:8];
      rreg <= ir_din[7:0];
    end else if (last && is_fetch) begin
      rreg <= {rreg[7], rreg[6:0] + 7'd1};
    end
  end

  always_comb begin
    bus_addr = 16'hFFFF;
    mreq     = 1'b0;
    ioreq    = 1'b0;
    rfsh     = 1'b0;
    if (active) begin
      if (is_fetch) begin
        if (half < HW'(4)) begin
          bus_addr = caddr;
          mreq     = (half != '0);
        end else begin
          bus_addr = {ireg, rreg};
          rfsh     = 1'b1;
          mreq     = (half == HW'(5)) || (half == HW'(6));
        end
      end else if (is_mem) begin
        bus_addr = caddr;
        mreq     = (half >= HW'(1)) && (half <= HW'(4));
      end else if (is_io) begin
        bus_addr = caddr;
        ioreq    = (half >= HW'(2)) && (half <= HW'(6));
      end else if (kind == K_INTIR) begin
        bus_addr = {ireg, rreg};
      end else begin
        bus_addr = caddr;
      end
    end
  end
endmodule

// File: rtl/z80_bus_seq_chk.sv
module z80_bus_seq_chk #(
  parameter int LEADIN_T = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        busy,
  input logic [15:0] bus_addr,
  input logic        mreq,
  input logic        ioreq,
  input logic        rfsh
);
  localparam int LEAD_H = 2 * LEADIN_T;
  int unsigned lc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lc <= 0;
    else if (lc < LEAD_H) lc <= lc + 1;
  end

  a_r1_leadin: assert property (@(posedge clk) disable iff (!rst_n)
    (lc < LEAD_H) |-> (bus_addr == 16'hFFFF && !mreq && !ioreq && !rfsh && !cmd_ready));

  a_r11_no_mreq_ioreq: assert property (@(posedge clk) disable iff (!rst_n)
    !(mreq && ioreq));

  a_r11_no_rfsh_ioreq: assert property (@(posedge clk) disable iff (!rst_n)
    !(rfsh && ioreq));

  a_r3_rfsh_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh) |-> !mreq);

  a_r9_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  a_r9_busy_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
endmodule

bind z80_bus_seq z80_bus_seq_chk #(.LEADIN_T(LEADIN_T)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .busy(busy), .bus_addr(bus_addr), .mreq(mreq), .ioreq(ioreq), .rfsh(rfsh)
);

// File: tb/z80_bus_seq_test.sv
`timescale 1ns/1ps
module z80_bus_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_kind = '0;
  logic [15:0] cmd_addr = '0;
  logic [3:0]  cmd_count = '0;
  logic        ir_wr = 1'b0;
  logic [15:0] ir_din = '0;
  logic        busy, mreq, ioreq, rfsh;
  logic [15:0] bus_addr;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_i = 8'h00;
  logic [7:0] m_r = 8'h00;

  always #2.5 clk = ~clk;

  z80_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
    .ir_wr(ir_wr), .ir_din(ir_din), .busy(busy), .bus_addr(bus_addr),
    .mreq(mreq), .ioreq(ioreq), .rfsh(rfsh)
  );

  function automatic string req_of(input logic [2:0] k);
    case (k)
      3'd0: return "R3";
      3'd1, 3'd2: return "R5";
      3'd3, 3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic int len_of(input logic [2:0] k, input logic [3:0] n);
    if (k == 3'd0 || k == 3'd3 || k == 3'd4) return 8;
    if (k == 3'd1 || k == 3'd2) return 6;
    return 2 * ((n == 0) ? 1 : int'(n));
  endfunction

  // {addr, mreq, ioreq, rfsh, busy, ready}
  function automatic logic [20:0] exp_of(input logic [2:0] k, input logic [15:0] a,
                                         input logic [3:0] n, input int h,
                                         input logic [7:0] ir_i, input logic [7:0] ir_r);
    logic [15:0] ad; logic mq, iq, rf; int ln;
    ln = len_of(k, n);
    ad = a; mq = 0; iq = 0; rf = 0;
    case (k)
      3'd0: if (h < 4) mq = (h != 0);
            else begin ad = {ir_i, ir_r}; rf = 1; mq = (h == 5 || h == 6); end
      3'd1, 3'd2: mq = (h >= 1 && h <= 4);
      3'd3, 3'd4: iq = (h >= 2 && h <= 6);
      3'd5: ad = {ir_i, ir_r};
      default: ;
    endcase
    return {ad, mq, iq, rf, (h != ln - 1), (h == ln - 1)};
  endfunction

  function automatic logic [20:0] act_now();
    return {bus_addr, mreq, ioreq, rfsh, busy, cmd_ready};
  endfunction

  task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual addr=%h m/i/r/b/y=%b expected addr=%h m/i/r/b/y=%b",
               req, act[20:5], act[4:0], exp[20:5], exp[4:0]);
    end
  endtask

  // Called at a negedge where the design is ready; returns at the negedge of the last half.
  task automatic run_cmd(input logic [2:0] k, input logic [15:0] a, input logic [3:0] n);
    int ln;
    ln = len_of(k, n);
    check("R9", {20'd0, cmd_ready}, {20'd0, 1'b1});
    cmd_valid = 1'b1; cmd_kind = k; cmd_addr = a; cmd_count = n;
    for (int h = 0; h < ln; h++) begin
      @(negedge clk);
      if (h == 0) begin cmd_valid = 1'b0; ir_wr = 1'b0; end
      check(req_of(k), act_now(), exp_of(k, a, n, h, m_i, m_r));
    end
    if (k == 3'd0) m_r = {m_r[7], m_r[6:0] + 7'd1};
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      ir_wr = 1'b0;
      check("R2", act_now(), {16'hFFFF, 3'b000, 1'b0, 1'b1});
    end
  endtask

  // Load on the coming edge; the load overrides any R step there (R10).
  task automatic load_ir(input logic [15:0] v);
    ir_wr = 1'b1; ir_din = v;
    m_i = v[15:8]; m_r = v[7:0];
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240407));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 lead-in
    for (int j = 0; j < 6; j++) begin
      check("R1", act_now(), {16'hFFFF, 3'b000, 1'b0, 1'b0});
      @(negedge clk);
    end
    check("R1", act_now(), {16'hFFFF, 3'b000, 1'b0, 1'b1});
    idle(2);

    // Directed: fetch then internal on {I,R}
    load_ir(16'hE000);
    idle(1);
    run_cmd(3'd0, 16'h0000, 4'd0);
    run_cmd(3'd5, 16'h1234, 4'd2);       // R7/R4: shows E001
    run_cmd(3'd0, 16'h0001, 4'd0);
    run_cmd(3'd5, 16'h0000, 4'd0);       // R7 count 0 -> 1 T-state, E002
    // R4 wrap of low 7 bits with bit 7 set and clear
    load_ir(16'hE0FF);
    idle(1);
    run_cmd(3'd0, 16'h4000, 4'd0);
    run_cmd(3'd5, 16'h0000, 4'd1);       // expect E080
    load_ir(16'h3F7F);
    idle(1);
    run_cmd(3'd0, 16'h4001, 4'd0);
    run_cmd(3'd5, 16'h0000, 4'd1);       // expect 3F00
    // R10 load on final edge of a fetch wins over the step
    run_cmd(3'd0, 16'h0100, 4'd0);
    load_ir(16'hA55A);
    run_cmd(3'd5, 16'h0000, 4'd3);       // expect A55A
    // R5, R6, R8 back to back (R9)
    run_cmd(3'd1, 16'hABCD, 4'd0);
    run_cmd(3'd2, 16'h9876, 4'd0);
    run_cmd(3'd3, 16'h80EF, 4'd0);
    run_cmd(3'd4, 16'hABCD, 4'd0);
    run_cmd(3'd6, 16'h0002, 4'd5);
    run_cmd(3'd7, 16'h0003, 4'd0);
    idle(2);

    // Random mix
    for (int c = 0; c < 600; c++) begin
      logic [2:0] k; logic [15:0] a; logic [3:0] n;
      k = 3'($urandom % 8);
      if ($urandom % 3 == 0) k = 3'd0;
      a = 16'($urandom);
      n = 4'($urandom);
      if ($urandom % 8 == 0) load_ir(16'($urandom));
      if ($urandom % 5 == 0) idle(1 + $urandom % 3);
      run_cmd(k, a, n);
    end
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule